// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block is a full-duplex serial channel that moves 8-bit characters on a shared shift clock. A host loads the transmit holding register with a write strobe and collects received characters from the receive holding register with a read strobe. It is set up through static configuration inputs. The block can generate the shift clock itself from a two-stage divider, which is a selectable power-of-two prescaler followed by an 8-bit reload counter. It can also follow a clock applied to its clock input pin, for the case where a remote master drives the clock.

Each transfer shifts one character out and one character in at the same time. Receiving depends on transmitting, because clock edges only occur while a character is being shifted out. A dummy write is therefore what starts a receive. In continuous receive mode, a read of the receive register starts the next transfer by itself. A clear-to-send input can hold back transmission, and a request-to-send output tells the link whether the receive register is free. Both interrupt outputs are single-cycle pulses. A character that arrives while the receive register is still unread sets an overrun flag.

Top module: `sync_serial_xcvr`

## Requirements
- R1: A `wr_i` pulse loads `wdata_i` and clears `tx_empty_o`. A transfer starts only while `te_i`=1 and `tx_empty_o`=0, with the clear-to-send gating of R4 also met. At the start, `tx_empty_o` returns to 1.
- R2: With the internal clock (`ext_clk_i`=0), each half period of `sclk_o` lasts (n+1)·D clock cycles. Here n is `brg_i` and D is 1, 2, 8 or 32 for `psel_i` = 0, 1, 2 or 3.
- R3: With `pol_i`=0, `sclk_o` idles high, `txd_o` changes on falling edges and the input is sampled on rising edges. With `pol_i`=1, the idle level and both edge roles are swapped. A transfer has 8 drive edges, each followed by a sample edge.
- R4: When `cts_en_i`=1 and `cts_ni`=1, no transfer starts. Once `cts_ni` goes low, the held character goes out.
- R5: A finished transfer loads the receive register and sets `rx_full_o` only if `re_i`=1 when it started. `te_i`=0 blocks reception along with transmission.
- R6: With `msb_first_i`=0, bit 0 is shifted first in both directions. With `msb_first_i`=1, bit 7 is shifted first.
- R7: With `inv_i`=1, the line levels of transmitted and received bits are inverted, so a looped-back character is received unchanged.
- R8: With `txirq_sel_i`=0, `tx_irq_o` pulses when a written character moves into the shifter. With `txirq_sel_i`=1, it pulses in the same cycle that a transfer completes.
- R9: `rx_irq_o` is a one-cycle pulse. It occurs together with the rise of `rx_full_o` when a character is latched. `rd_i` clears `rx_full_o`.
- R10: If `rx_full_o`=1 when the 7th bit of the next character is sampled, `overrun_o` sets and `rx_full_o` stays 1. No `rx_irq_o` pulse is produced for that character. `overrun_o` clears while `re_i`=0.
- R11: With `cont_i`=1 and `re_i`=1, a read of the receive register starts another transfer without a write. That transfer shifts out the last written character again.
- R12: With `rts_en_i`=1, `rts_no` is 0 exactly when `re_i`=1 and `rx_full_o`=0. With `rts_en_i`=0, it is held at 0.
- R13: With `ext_clk_i`=1, shifting follows edges on `sclk_i`, with the edge roles set by R3, and `sclk_oe_o`=0. With `ext_clk_i`=0, `sclk_oe_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| te_i | input | 1 | Transmit enable |
| re_i | input | 1 | Receive enable |
| ext_clk_i | input | 1 | 1: follow `sclk_i`; 0: generate clock |
| psel_i | input | 2 | Prescaler select (/1, /2, /8, /32) |
| brg_i | input | 8 | Divider reload value n |
| pol_i | input | 1 | Clock polarity |
| msb_first_i | input | 1 | Bit order |
| inv_i | input | 1 | Data line inversion |
| cont_i | input | 1 | Continuous receive mode |
| txirq_sel_i | input | 1 | Transmit interrupt on load (0) or completion (1) |
| cts_en_i | input | 1 | Clear-to-send gating enable |
| rts_en_i | input | 1 | Request-to-send output enable |
| wr_i | input | 1 | Transmit register write strobe |
| wdata_i | input | 8 | Transmit data |
| rd_i | input | 1 | Receive register read strobe |
| rx_data_o | output | 8 | Receive register |
| tx_empty_o | output | 1 | Transmit register empty |
| rx_full_o | output | 1 | Receive register holds unread data |
| overrun_o | output | 1 | Overrun flag |
| tx_irq_o | output | 1 | Transmit interrupt pulse |
| rx_irq_o | output | 1 | Receive interrupt pulse |
| sclk_i | input | 1 | External shift clock |
| sclk_o | output | 1 | Generated shift clock |
| sclk_oe_o | output | 1 | Shift clock output enable |
| txd_o | output | 1 | Serial data out |
| rxd_i | input | 1 | Serial data in |
| cts_ni | input | 1 | Clear-to-send, active low |
| rts_no | output | 1 | Request-to-send, active low |

## Verification
The overrun case is the hardest to reach from the ports. The receive register has to stay unread while a second dummy write drives a full character through the loop. The bench then has to see `overrun_o` rise on exactly the 7th sample edge, which it counts on `sclk_o`, and confirm that no receive pulse follows. Continuous receive is the other awkward case, because the second transfer has no write behind it. The bench reaches it with a single read and then stops the chain by clearing the mode before its next read.

// File: rtl/ssio_pkg.sv
package ssio_pkg;
  localparam int unsigned CHAR_W = 8;
  localparam int unsigned CNT_W  = $clog2(CHAR_W + 1);

  typedef struct packed {
    logic evt;    // a shift clock edge occurred
    logic drive;  // 1: data change edge, 0: sample edge
  } sclk_evt_t;

  // log2 of prescaler ratio per select code: /1, /2, /8, /32
  function automatic int unsigned pre_shift(input logic [1:0] sel);
    case (sel)
      2'd0:    return 0;
      2'd1:    return 1;
      2'd2:    return 3;
      default: return 5;
    endcase
  endfunction
endpackage

// File: rtl/ssio_sync.sv
module ssio_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= RST_VAL;
        else         ff_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/ssio_clk_gen.sv
module ssio_clk_gen
  import ssio_pkg::*;
#(
  parameter int unsigned BRG_W       = 8,
  parameter int unsigned PRE_W       = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busy_i,
  input  logic             start_i,
  input  logic             ext_i,
  input  logic             pol_i,
  input  logic [1:0]       psel_i,
  input  logic [BRG_W-1:0] brg_i,
  input  logic             sclk_pin_i,
  output logic             sclk_o,
  output sclk_evt_t        evt_o
);
  logic [PRE_W-1:0] pre_cnt_q;
  logic [PRE_W-1:0] pre_lim;
  logic [BRG_W-1:0] brg_cnt_q;
  logic             sclk_q;
  logic             fj_tick;
  logic             half_tick;
  logic             ext_s;
  logic             ext_prev_q;
  logic             ext_edge;

  assign pre_lim   = PRE_W'((32'd1 << pre_shift(psel_i)) - 32'd1);
  assign fj_tick   = (pre_cnt_q == pre_lim);
  assign half_tick = busy_i & ~ext_i & fj_tick & (brg_cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_cnt_q <= '0;
      brg_cnt_q <= '0;
    end else if (start_i) begin
      pre_cnt_q <= '0;
      brg_cnt_q <= brg_i;
    end else if (busy_i) begin
      pre_cnt_q <= fj_tick ? '0 : pre_cnt_q + 1'b1;
      if (fj_tick) brg_cnt_q <= (brg_cnt_q == '0) ? brg_i : brg_cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sclk_q <= 1'b1;
    else if (!busy_i)   sclk_q <= ~pol_i;
    else if (half_tick) sclk_q <= ~sclk_q;
  end

  ssio_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sclk_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sclk_pin_i),
    .q_o   (ext_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_prev_q <= 1'b1;
    else         ext_prev_q <= ext_s;
  end

  assign ext_edge = ext_s ^ ext_prev_q;

  always_comb begin
    if (ext_i) begin
      evt_o.evt   = busy_i & ext_edge;
      evt_o.drive = (ext_s == pol_i);
    end else begin
      evt_o.evt   = half_tick;
      evt_o.drive = (~sclk_q == pol_i);
    end
  end

  assign sclk_o = sclk_q;

  AST_SCLK_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !busy_i && !$past(busy_i) && $stable(pol_i)) |-> (sclk_q == ~pol_i)); // R3
  AST_NO_EDGE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !evt_o.evt); // R1
endmodule

// File: rtl/ssio_shifter.sv
module ssio_shifter
  import ssio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CHAR_W-1:0] tx_word_i,
  input  sclk_evt_t         evt_i,
  input  logic              inv_i,
  input  logic              rxd_i,
  output logic              busy_o,
  output logic              txd_o,
  output logic              sample7_o,
  output logic              done_o,
  output logic [CHAR_W-1:0] rx_word_o
);
  logic [CHAR_W-1:0] tx_sh_q;
  logic [CHAR_W-1:0] rx_sh_q;
  logic [CNT_W-1:0]  n_smp_q;
  logic              busy_q;
  logic              txd_q;
  logic              rx_bit;
  logic              smp_evt;

  assign rx_bit  = rxd_i ^ inv_i;
  assign smp_evt = busy_q & evt_i.evt & ~evt_i.drive;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      n_smp_q <= '0;
      txd_q   <= 1'b1;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      tx_sh_q <= tx_word_i;
      n_smp_q <= '0;
    end else if (busy_q && evt_i.evt) begin
      if (evt_i.drive) begin
        txd_q   <= tx_sh_q[0] ^ inv_i;
        tx_sh_q <= tx_sh_q >> 1;
      end else begin
        rx_sh_q <= {rx_bit, rx_sh_q[CHAR_W-1:1]};
        n_smp_q <= n_smp_q + 1'b1;
        if (n_smp_q == CNT_W'(CHAR_W - 1)) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o    = busy_q;
  assign txd_o     = txd_q;
  assign done_o    = smp_evt & (n_smp_q == CNT_W'(CHAR_W - 1));
  assign sample7_o = smp_evt & (n_smp_q == CNT_W'(CHAR_W - 2));
  assign rx_word_o = {rx_bit, rx_sh_q[CHAR_W-1:1]};

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o); // R3
  AST_TXD_QUIET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !busy_o && !$past(busy_o)) |-> $stable(txd_o)); // R3
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
  import ssio_pkg::*;
#(
  parameter int unsigned BRG_W       = 8,
  parameter int unsigned PRE_W       = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              te_i,
  input  logic              re_i,
  input  logic              ext_clk_i,
  input  logic [1:0]        psel_i,
  input  logic [BRG_W-1:0]  brg_i,
  input  logic              pol_i,
  input  logic              msb_first_i,
  input  logic              inv_i,
  input  logic              cont_i,
  input  logic              txirq_sel_i,
  input  logic              cts_en_i,
  input  logic              rts_en_i,
  input  logic              wr_i,
  input  logic [CHAR_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [CHAR_W-1:0] rx_data_o,
  output logic              tx_empty_o,
  output logic              rx_full_o,
  output logic              overrun_o,
  output logic              tx_irq_o,
  output logic              rx_irq_o,
  input  logic              sclk_i,
  output logic              sclk_o,
  output logic              sclk_oe_o,
  output logic              txd_o,
  input  logic              rxd_i,
  input  logic              cts_ni,
  output logic              rts_no
);
  logic [CHAR_W-1:0] tx_buf_q, tx_rev, tx_word;
  logic [CHAR_W-1:0] rx_buf_q, rx_raw, rx_rev;
  logic              tx_empty_q, rx_full_q, ovr_q, rx_on_q, cont_arm_q;
  logic              tx_irq_q, rx_irq_q;
  logic              cts_s, cts_ok, cont_go, start, busy, done, sample7;
  logic              rx_take;
  sclk_evt_t         evt;

  ssio_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cts_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cts_ni),
    .q_o   (cts_s)
  );

  for (genvar g = 0; g < CHAR_W; g++) begin : g_rev
    assign tx_rev[g] = tx_buf_q[CHAR_W-1-g];
    assign rx_rev[g] = rx_raw[CHAR_W-1-g];
  end

  assign tx_word = msb_first_i ? tx_rev : tx_buf_q;
  assign cts_ok  = ~cts_en_i | ~cts_s;
  assign cont_go = cont_i & cont_arm_q & re_i & ~rx_full_q;
  assign start   = ~busy & te_i & cts_ok & (~tx_empty_q | cont_go);
  assign rx_take = done & rx_on_q;

  ssio_clk_gen #(.BRG_W(BRG_W), .PRE_W(PRE_W), .SYNC_STAGES(SYNC_STAGES)) u_clk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .busy_i    (busy),
    .start_i   (start),
    .ext_i     (ext_clk_i),
    .pol_i     (pol_i),
    .psel_i    (psel_i),
    .brg_i     (brg_i),
    .sclk_pin_i(sclk_i),
    .sclk_o    (sclk_o),
    .evt_o     (evt)
  );

  ssio_shifter u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .tx_word_i(tx_word),
    .evt_i    (evt),
    .inv_i    (inv_i),
    .rxd_i    (rxd_i),
    .busy_o   (busy),
    .txd_o    (txd_o),
    .sample7_o(sample7),
    .done_o   (done),
    .rx_word_o(rx_raw)
  );

  // transmit side
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_buf_q   <= '0;
      tx_empty_q <= 1'b1;
      cont_arm_q <= 1'b0;
      rx_on_q    <= 1'b0;
      tx_irq_q   <= 1'b0;
    end else begin
      tx_irq_q <= txirq_sel_i ? done : (start & ~tx_empty_q);
      if (start) begin
        tx_empty_q <= 1'b1;
        rx_on_q    <= re_i;
        cont_arm_q <= 1'b0;
      end
      if (rd_i && cont_i) cont_arm_q <= 1'b1;
      else if (!cont_i)   cont_arm_q <= 1'b0;
      if (wr_i) begin
        tx_buf_q   <= wdata_i;
        tx_empty_q <= 1'b0;
      end
    end
  end

  // receive side
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_buf_q  <= '0;
      rx_full_q <= 1'b0;
      ovr_q     <= 1'b0;
      rx_irq_q  <= 1'b0;
    end else begin
      rx_irq_q <= rx_take & (~rx_full_q | rd_i);
      if (rd_i) rx_full_q <= 1'b0;
      if (rx_take) begin
        rx_buf_q <= msb_first_i ? rx_rev : rx_raw;
        if (!rx_full_q || rd_i) rx_full_q <= 1'b1;
      end
      if (!re_i)                                       ovr_q <= 1'b0;
      else if (sample7 && rx_on_q && rx_full_q && !rd_i) ovr_q <= 1'b1;
    end
  end

  assign rx_data_o  = rx_buf_q;
  assign tx_empty_o = tx_empty_q;
  assign rx_full_o  = rx_full_q;
  assign overrun_o  = ovr_q;
  assign tx_irq_o   = tx_irq_q;
  assign rx_irq_o   = rx_irq_q;
  assign sclk_oe_o  = ~ext_clk_i;
  assign rts_no     = rts_en_i & ~(re_i & ~rx_full_q);

  AST_TE_GATES_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!te_i && !busy) |=> !busy); // R1
  AST_CTS_HOLDS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cts_en_i && cts_s && !busy) |=> !busy); // R4
  AST_RX_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |=> !rx_irq_o); // R9
  AST_RX_FULL_WITH_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_full_o) |-> rx_irq_o); // R9
  AST_OVR_KEEPS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> (rx_full_o && !rx_irq_o)); // R10
  AST_OVR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> !overrun_o); // R10
endmodule

// File: tb/sync_serial_xcvr_test.sv
module sync_serial_xcvr_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic te = 0, re = 0, ext = 0, pol = 0, msb = 0, inv = 0, cont = 0, tsel = 0;
  logic cts_en = 0, rts_en = 1, wr = 0, rd = 0, sclk_in = 1, rxd_drv = 1, cts_n = 1, loop = 1;
  logic [1:0] psel = 0;
  logic [7:0] brg = 0, wdata = 0;
  logic [7:0] rx_data;
  logic tx_empty, rx_full, overrun, tx_irq, rx_irq, sclk, sclk_oe, txd, rts_n, rxd;

  assign rxd = loop ? txd : rxd_drv;

  sync_serial_xcvr uut (
    .clk_i(clk), .rst_ni(rst_ni), .te_i(te), .re_i(re), .ext_clk_i(ext), .psel_i(psel),
    .brg_i(brg), .pol_i(pol), .msb_first_i(msb), .inv_i(inv), .cont_i(cont),
    .txirq_sel_i(tsel), .cts_en_i(cts_en), .rts_en_i(rts_en), .wr_i(wr), .wdata_i(wdata),
    .rd_i(rd), .rx_data_o(rx_data), .tx_empty_o(tx_empty), .rx_full_o(rx_full),
    .overrun_o(overrun), .tx_irq_o(tx_irq), .rx_irq_o(rx_irq), .sclk_i(sclk_in),
    .sclk_o(sclk), .sclk_oe_o(sclk_oe), .txd_o(txd), .rxd_i(rxd), .cts_ni(cts_n), .rts_no(rts_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int tx_cnt = 0, rx_cnt = 0, both_cnt = 0, tx_cyc = 0, rx_cyc = 0;
  int clr_req = 0, clr_seen = 0;
  int smp_cnt = 0, hp_min = 0, hp_max = 0, last_tog = -1, ovr_smp = -1;
  int cap_n = 0;
  logic cap [0:63];
  logic sclk_prev = 1'b1, ovr_prev = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // cycle monitor: request-to-send model, interrupt log, clock edge log
  always @(negedge clk) begin
    cyc++;
    if (clr_seen != clr_req) begin
      clr_seen = clr_req;
      cap_n = 0; smp_cnt = 0; hp_min = 1000000; hp_max = 0; last_tog = -1; ovr_smp = -1;
    end
    if (rst_ni) begin
      chk(rts_n == (rts_en && !(re && !rx_full)), "R12 rts", rts_n, rts_en && !(re && !rx_full));
      if (tx_irq) begin tx_cnt++; tx_cyc = cyc; end
      if (rx_irq) begin rx_cnt++; rx_cyc = cyc; end
      if (tx_irq && rx_irq) both_cnt++;
      if (sclk_oe && sclk != sclk_prev) begin
        if (last_tog >= 0) begin
          if (cyc - last_tog < hp_min) hp_min = cyc - last_tog;
          if (cyc - last_tog > hp_max) hp_max = cyc - last_tog;
        end
        last_tog = cyc;
        if (sclk == !pol) begin
          smp_cnt++;
          if (cap_n < 64) begin cap[cap_n] = txd; cap_n++; end
        end else if (smp_cnt == 8) smp_cnt = 0;
      end
      if (overrun && !ovr_prev) ovr_smp = smp_cnt;
    end
    sclk_prev = sclk;
    ovr_prev  = overrun;
  end

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic mon_clear();
    clr_req++;
    step(2);
  endtask

  task automatic put(input logic [7:0] b);
    wr = 1; wdata = b; step(1); wr = 0;
  endtask

  task automatic get(output logic [7:0] b);
    b = rx_data; rd = 1; step(1); rd = 0;
  endtask

  task automatic wait_rx(input int base, input int lim, input string req);
    int k = 0;
    while (rx_cnt == base && k < lim) begin step(1); k++; end
    step(1);
    chk(rx_cnt == base + 1, req, rx_cnt - base, 1);
  endtask

  task automatic wait_tx(input int base, input int lim, input string req);
    int k = 0;
    while (tx_cnt == base && k < lim) begin step(1); k++; end
    step(1);
    chk(tx_cnt == base + 1, req, tx_cnt - base, 1);
  endtask

  function automatic logic exp_bit(input logic [7:0] b, input int i);
    return (msb ? b[7-i] : b[i]) ^ inv;
  endfunction

  task automatic check_bits(input logic [7:0] b, input string req);
    chk(cap_n == 8, req, cap_n, 8);
    for (int i = 0; i < 8; i++)
      chk(cap[i] == exp_bit(b, i), req, cap[i], exp_bit(b, i));
  endtask

  // loopback transfer in internal clock mode, checks serial bits and received data
  task automatic loop_xfer(input logic [7:0] b, input int lim, input string req);
    int base;
    logic [7:0] got;
    mon_clear();
    base = rx_cnt;
    put(b);
    wait_rx(base, lim, req);
    check_bits(b, req);
    get(got);
    chk(got == b, req, got, b);
  endtask

  initial begin : stim
    int base, tbase;
    logic [7:0] got;
    step(3);
    rst_ni = 1;
    step(1);
    // reset state
    chk(tx_empty == 1'b1, "R1 reset empty", tx_empty, 1);
    chk(rx_full == 1'b0, "R9 reset full", rx_full, 0);
    chk(overrun == 1'b0, "R10 reset ovr", overrun, 0);
    chk(sclk == 1'b1, "R3 idle high pol0", sclk, 1);
    chk(sclk_oe == 1'b1, "R13 oe internal", sclk_oe, 1);

    // R1/R5: no transfer without te
    re = 1;
    base = rx_cnt;
    put(8'h5A);
    step(60);
    chk(tx_empty == 1'b0, "R1 te=0 holds data", tx_empty, 0);
    chk(rx_cnt == base, "R5 te=0 no receive", rx_cnt - base, 0);
    mon_clear();
    te = 1;
    wait_rx(base, 200, "R5 receive after te");
    chk(tx_empty == 1'b1, "R1 empty after start", tx_empty, 1);
    check_bits(8'h5A, "R6 lsb first bits");
    get(got);
    chk(got == 8'h5A, "R5 data", got, 8'h5A);
    chk(rx_full == 1'b0, "R9 read clears full", rx_full, 0);

    // R2 divider rates
    psel = 1; brg = 2;
    loop_xfer(8'hC3, 400, "R2 xfer /2 n=2");
    chk(hp_min == 6 && hp_max == 6, "R2 half period 6", hp_max, 6);
    psel = 2; brg = 1;
    loop_xfer(8'h3C, 800, "R2 xfer /8 n=1");
    chk(hp_min == 16 && hp_max == 16, "R2 half period 16", hp_max, 16);
    psel = 3; brg = 0;
    loop_xfer(8'h81, 1200, "R2 xfer /32 n=0");
    chk(hp_min == 32 && hp_max == 32, "R2 half period 32", hp_max, 32);
    psel = 0; brg = 3;
    loop_xfer(8'h17, 400, "R2 xfer /1 n=3");
    chk(hp_min == 4 && hp_max == 4, "R2 half period 4", hp_max, 4);
    brg = 0;

    // R6 msb first, R7 inversion, R3 polarity
    msb = 1;
    loop_xfer(8'hB4, 200, "R6 msb first");
    inv = 1;
    loop_xfer(8'h6D, 200, "R7 inverted");
    msb = 0;
    loop_xfer(8'hE2, 200, "R7 inverted lsb");
    inv = 0;
    pol = 1;
    step(3);
    chk(sclk == 1'b0, "R3 idle low pol1", sclk, 0);
    loop_xfer(8'h9B, 200, "R3 pol1 xfer");
    chk(sclk == 1'b0, "R3 returns low", sclk, 0);
    pol = 0;
    step(3);

    // R4 clear-to-send
    cts_en = 1; cts_n = 1;
    base = rx_cnt;
    put(8'h44);
    step(40);
    chk(tx_empty == 1'b0, "R4 cts blocks", tx_empty, 0);
    chk(rx_cnt == base, "R4 nothing sent", rx_cnt - base, 0);
    cts_n = 0;
    wait_rx(base, 200, "R4 sends after cts low");
    get(got);
    chk(got == 8'h44, "R4 data", got, 8'h44);
    cts_en = 0; cts_n = 1;

    // R8 transmit interrupt modes
    tsel = 0;
    base = rx_cnt; tbase = tx_cnt;
    put(8'h21);
    wait_rx(base, 200, "R8 mode0 xfer");
    chk(tx_cnt == tbase + 1, "R8 mode0 one pulse", tx_cnt - tbase, 1);
    chk(rx_cyc - tx_cyc >= 15, "R8 mode0 at load", rx_cyc - tx_cyc, 15);
    get(got);
    tsel = 1;
    base = rx_cnt; tbase = both_cnt;
    put(8'h22);
    wait_rx(base, 200, "R8 mode1 xfer");
    chk(both_cnt == tbase + 1, "R8 mode1 at completion", both_cnt - tbase, 1);
    get(got);

    // R5 re=0: transfer runs, nothing received
    re = 0;
    base = rx_cnt; tbase = tx_cnt;
    put(8'h77);
    wait_tx(tbase, 200, "R5 tx without re");
    step(3);
    chk(rx_full == 1'b0, "R5 re=0 no full", rx_full, 0);
    chk(rx_cnt == base, "R5 re=0 no irq", rx_cnt - base, 0);
    re = 1;
    step(2);

    // R10 overrun
    base = rx_cnt;
    put(8'h22);
    wait_rx(base, 200, "R10 first char");
    mon_clear();
    tbase = tx_cnt;
    put(8'h11);
    wait_tx(tbase, 200, "R10 second char done");
    chk(overrun == 1'b1, "R10 overrun set", overrun, 1);
    chk(ovr_smp == 7, "R10 at 7th bit", ovr_smp, 7);
    chk(rx_full == 1'b1, "R10 full kept", rx_full, 1);
    chk(rx_cnt == base + 1, "R10 no rx irq", rx_cnt - base, 1);
    re = 0;
    step(2);
    chk(overrun == 1'b0, "R10 cleared by re=0", overrun, 0);
    get(got);
    re = 1;
    step(2);

    // R11 continuous receive
    cont = 1;
    base = rx_cnt;
    put(8'h96);
    wait_rx(base, 200, "R11 first");
    get(got);
    chk(got == 8'h96, "R11 first data", got, 8'h96);
    base = rx_cnt;
    wait_rx(base, 200, "R11 auto restart");
    chk(rx_data == 8'h96, "R11 resent data", rx_data, 8'h96);
    chk(tx_empty == 1'b1, "R11 no write needed", tx_empty, 1);
    cont = 0;
    step(1);
    get(got);
    base = rx_cnt;
    step(80);
    chk(rx_cnt == base, "R11 stops when off", rx_cnt - base, 0);

    // R13 external clock
    ext = 1; loop = 0; sclk_in = 1;
    step(4);
    chk(sclk_oe == 1'b0, "R13 oe off", sclk_oe, 0);
    base = rx_cnt;
    put(8'hA5);
    step(3);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] rb;
      rb = 8'h3C;
      sclk_in = 0; rxd_drv = rb[i];
      step(8);
      chk(txd == exp_bit(8'hA5, i), "R13 tx bit", txd, exp_bit(8'hA5, i));
      sclk_in = 1;
      step(8);
    end
    step(4);
    chk(rx_cnt == base + 1, "R13 received", rx_cnt - base, 1);
    chk(rx_data == 8'h3C, "R13 data", rx_data, 8'h3C);
    get(got);

    step(5);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule